// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides, for every destination address presented on the receive side of an Ethernet MAC, whether the frame is kept or dropped. An address arrives as a 48-bit value with a one-cycle valid strobe. One clock later the block returns an accept flag and a two-bit code naming the path that admitted it. Treat the address as a 48-bit number with byte 0 as its least significant byte and byte 5 as its most significant byte.

There are three ways in. The first is a bank of sixteen exact-match entries. Entry 0 is meant for the station's own unicast address, and entries 1 to 15 are meant for multicast groups. The second is a 4096-bit hash table, used only for multicast addresses. Its 12-bit index is a window cut from the upper address bits, and a two-bit filter-type input picks which window. The third is an all-ones broadcast address, admitted while a separate enable input is high.

A 32-bit word-addressed register port loads the exact-match entries and the hash table words. It returns their current contents on reads, so software can set single hash bits by read-modify-write.

Top module: `mc_addr_filter`

## Requirements
- R1: Exact-match entry n occupies register words 2n and 2n+1. The low word holds address bits 31:0, with byte 0 in bits 7:0. The high word holds address bits 47:32 in its bits 15:0, with byte 4 in bits 7:0, and bit 31 of the high word is the entry's valid flag. A valid entry equal to the incoming address gives an exact match. There are 16 entries, at register addresses 0 to 31.
- R2: An entry whose valid flag is clear never matches, whatever its address bits hold.
- R3: An address with bit 0 clear is unicast. It is accepted only on an exact match and never through the hash table.
- R4: The 12-bit hash index is taken from the address according to the filter type: type 0 takes bits 47:36, type 1 takes bits 46:35, type 2 takes bits 45:34 and type 3 takes bits 43:32.
- R5: Hash table word w sits at register address 128+w, for w from 0 to 127. Index bits 11:5 select the word and index bits 4:0 select the bit in it. A multicast address whose indexed bit is 1 is accepted with the hash code.
- R6: Reads return the current contents of the addressed word. Unused bits of a high word read as 0. Addresses 32 to 127 read as 0, and writes to them change nothing.
- R7: The address 48'hFFFF_FFFF_FFFF is accepted with the broadcast code when the broadcast enable is 1. When the enable is 0 it is rejected unless an exact entry holds it, and it never passes through the hash table.
- R8: When more than one path applies, exact match wins over broadcast, and broadcast wins over hash.
- R9: The decision appears exactly one clock after the address strobe, with the decision valid flag high for one cycle. While that flag is low, the code is 0 and accept is low.
- R10: Reset clears every exact-match entry (including its valid flag) and every hash table word.
- R11: Code values are 0 for none, 1 for exact, 2 for hash and 3 for broadcast. Accept is 1 exactly when the code is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| filt_type | input | 2 | Hash window select |
| bcast_en | input | 1 | Broadcast accept enable |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, byte 0 in bits 7:0 |
| dec_valid | output | 1 | Decision valid, one clock after da_valid |
| dec_accept | output | 1 | Frame accepted |
| dec_code | output | 2 | Matching path: 0 none, 1 exact, 2 hash, 3 broadcast |

## Verification
A behavioural reference model of the entries and the table predicts the decision in every cycle, so every strobe is compared, idle cycles included.

Directed addresses are each chosen to separate one rule from another:
- a unicast address whose hash bit is set separates the unicast rule from the hash lookup;
- a multicast address that is also stored as an exact entry separates exact from hash;
- the broadcast address, tried with the enable both high and low and with hash bit 4095 set, separates the broadcast path from the hash path;
- an address hashed under one filter type and presented under another exposes a wrong window.

Back-to-back strobes, invalid entries, unmapped writes and a reset in the middle of the run complete the directed set. A pseudo-random stream mixing stored and fresh addresses follows.

// File: rtl/maf_pkg.sv
package maf_pkg;
  typedef enum logic [1:0] {
    MC_NONE  = 2'd0,
    MC_EXACT = 2'd1,
    MC_HASH  = 2'd2,
    MC_BCAST = 2'd3
  } match_code_t;
endpackage

// File: rtl/maf_exact_bank.sv
module maf_exact_bank #(
  parameter int N_ENT = 16,
  parameter int DW    = 32,
  parameter int MACW  = 48,
  localparam int WIW  = $clog2(2 * N_ENT),
  localparam int HIW  = MACW - DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [WIW-1:0]  wr_word,
  input  logic [DW-1:0]   wr_data,
  input  logic [WIW-1:0]  rd_word,
  output logic [DW-1:0]   rd_data,
  input  logic [MACW-1:0] da,
  output logic            hit
);
  logic [N_ENT-1:0][DW-1:0]  lo_all;
  logic [N_ENT-1:0][HIW-1:0] hi_all;
  logic [N_ENT-1:0]          vld_all;
  logic [N_ENT-1:0]          match;

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    logic [DW-1:0]  lo_q, lo_d;
    logic [HIW-1:0] hi_q, hi_d;
    logic           vld_q, vld_d;
    logic           lo_we, hi_we;

    assign lo_we = wr_en && (wr_word == WIW'(2 * e));
    assign hi_we = wr_en && (wr_word == WIW'(2 * e + 1));

    always_comb begin
      lo_d  = lo_q;
      hi_d  = hi_q;
      vld_d = vld_q;
      if (lo_we) lo_d = wr_data;
      if (hi_we) begin
        hi_d  = wr_data[HIW-1:0];
        vld_d = wr_data[DW-1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q  <= '0;
        hi_q  <= '0;
        vld_q <= 1'b0;
      end else if (lo_we || hi_we) begin
        lo_q  <= lo_d;
        hi_q  <= hi_d;
        vld_q <= vld_d;
      end
    end

    assign lo_all[e]  = lo_q;
    assign hi_all[e]  = hi_q;
    assign vld_all[e] = vld_q;
    assign match[e]   = vld_q && (da == {hi_q, lo_q});

    // R2: an entry whose valid flag was cleared by its last high-word write
    // cannot report a match on the following cycle
    a_r2_cleared_entry_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_we && !wr_data[DW-1]) |=> !match[e]);
  end

  assign hit = |match;

  always_comb begin
    if (rd_word[0])
      rd_data = {vld_all[rd_word[WIW-1:1]], {(DW-1-HIW){1'b0}}, hi_all[rd_word[WIW-1:1]]};
    else
      rd_data = lo_all[rd_word[WIW-1:1]];
  end
endmodule

// File: rtl/maf_hash_index.sv
module maf_hash_index #(
  parameter int MACW = 48,
  parameter int HW   = 12,
  localparam int LSB0 = MACW - HW,
  localparam int LSB1 = LSB0 - 1,
  localparam int LSB2 = LSB0 - 2,
  localparam int LSB3 = LSB0 - 4
) (
  input  logic [MACW-1:0] da,
  input  logic [1:0]      ftype,
  output logic [HW-1:0]   idx
);
  always_comb begin
    unique case (ftype)
      2'd0:    idx = da[LSB0 +: HW];
      2'd1:    idx = da[LSB1 +: HW];
      2'd2:    idx = da[LSB2 +: HW];
      default: idx = da[LSB3 +: HW];
    endcase
  end
endmodule

// File: rtl/maf_hash_table.sv
module maf_hash_table #(
  parameter int HW   = 12,
  parameter int DW   = 32,
  localparam int BIW   = $clog2(DW),
  localparam int WIW   = HW - BIW,
  localparam int WORDS = 2 ** WIW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [WIW-1:0] wr_word,
  input  logic [DW-1:0]  wr_data,
  input  logic [WIW-1:0] rd_word,
  output logic [DW-1:0]  rd_data,
  input  logic [HW-1:0]  lk_idx,
  output logic           lk_bit
);
  logic [WORDS-1:0][DW-1:0] tbl_all;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [DW-1:0] word_q, word_d;
    logic          word_we;

    assign word_we = wr_en && (wr_word == WIW'(w));

    always_comb begin
      word_d = word_q;
      if (word_we) word_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '0;
      else if (word_we) word_q <= word_d;
    end

    assign tbl_all[w] = word_q;
  end

  assign rd_data = tbl_all[rd_word];
  assign lk_bit  = tbl_all[lk_idx[HW-1:BIW]][lk_idx[BIW-1:0]];

  // R5: a table write becomes visible on the read port from the next cycle
  a_r5_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_word == wr_word) |=> (rd_data == $past(wr_data)));
endmodule

// File: rtl/mc_addr_filter.sv
module mc_addr_filter #(
  parameter int N_ENT = 16,
  parameter int HW    = 12,
  parameter int DW    = 32,
  parameter int MACW  = 48,
  localparam int EXW    = $clog2(2 * N_ENT),
  localparam int HWI    = HW - $clog2(DW),
  localparam int REG_AW = ((HWI > EXW) ? HWI : EXW) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [1:0]        filt_type,
  input  logic              bcast_en,
  input  logic              da_valid,
  input  logic [MACW-1:0]   da,
  output logic              dec_valid,
  output logic              dec_accept,
  output logic [1:0]        dec_code
);
  import maf_pkg::*;

  logic          sel_hash, sel_exact;
  logic [DW-1:0] ex_rd, tb_rd;
  logic          ex_hit, tb_bit;
  logic [HW-1:0] h_idx;
  logic          is_bcast, is_mcast, hash_ok, bc_ok;
  match_code_t   code_d, code_q;
  logic          acc_d, acc_q, vld_q;

  assign sel_hash  = reg_addr[REG_AW-1];
  assign sel_exact = !reg_addr[REG_AW-1] &&
                     (reg_addr[REG_AW-2:0] < (REG_AW-1)'(2 * N_ENT));

  maf_exact_bank #(.N_ENT(N_ENT), .DW(DW), .MACW(MACW)) u_exact (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en && sel_exact), .wr_word(reg_addr[EXW-1:0]), .wr_data(reg_wdata),
    .rd_word(reg_addr[EXW-1:0]), .rd_data(ex_rd),
    .da(da), .hit(ex_hit)
  );

  maf_hash_index #(.MACW(MACW), .HW(HW)) u_index (
    .da(da), .ftype(filt_type), .idx(h_idx)
  );

  maf_hash_table #(.HW(HW), .DW(DW)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en && sel_hash), .wr_word(reg_addr[HWI-1:0]), .wr_data(reg_wdata),
    .rd_word(reg_addr[HWI-1:0]), .rd_data(tb_rd),
    .lk_idx(h_idx), .lk_bit(tb_bit)
  );

  always_comb begin
    if (sel_hash)       reg_rdata = tb_rd;
    else if (sel_exact) reg_rdata = ex_rd;
    else                reg_rdata = '0;
  end

  assign is_bcast = &da;
  assign is_mcast = da[0];
  assign bc_ok    = is_bcast && bcast_en;
  assign hash_ok  = is_mcast && !is_bcast && tb_bit;

  always_comb begin
    code_d = MC_NONE;
    if (da_valid) begin
      if (ex_hit)       code_d = MC_EXACT;
      else if (bc_ok)   code_d = MC_BCAST;
      else if (hash_ok) code_d = MC_HASH;
    end
    acc_d = da_valid && (ex_hit || bc_ok || hash_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      acc_q  <= 1'b0;
      code_q <= MC_NONE;
    end else begin
      vld_q  <= da_valid;
      acc_q  <= acc_d;
      code_q <= code_d;
    end
  end

  assign dec_valid  = vld_q;
  assign dec_accept = acc_q;
  assign dec_code   = code_q;

  // R9: a strobe yields a decision on the next clock
  a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    da_valid |=> dec_valid);
  // R9: no decision means code none and no accept
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (dec_code == MC_NONE && !dec_accept));
  // R3: unicast never admitted through the hash table
  a_r3_unicast_no_hash: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && !da[0]) |=> (dec_code != MC_HASH));
  // R7: broadcast code only while enabled
  a_r7_bcast_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && !bcast_en) |=> (dec_code != MC_BCAST));
  // R11: accept agrees with the code
  a_r11_accept_code: assert property (@(posedge clk) disable iff (!rst_n)
    dec_accept == (dec_code != MC_NONE));
endmodule

// File: tb/tb_mc_addr_filter.sv
module tb_mc_addr_filter;
  logic        clk;
  logic        rst_n;
  logic        reg_wr_en;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [1:0]  filt_type;
  logic        bcast_en;
  logic        da_valid;
  logic [47:0] da;
  logic        dec_valid, dec_accept;
  logic [1:0]  dec_code;

  int errors = 0;
  int checks = 0;
  string cur_req = "R9";

  // reference state
  logic [31:0] m_lo  [16];
  logic [31:0] m_hi  [16];
  logic [31:0] m_tbl [128];
  logic        e_valid, e_acc;
  logic [1:0]  e_code;

  mc_addr_filter dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .filt_type(filt_type),
    .bcast_en(bcast_en), .da_valid(da_valid), .da(da), .dec_valid(dec_valid),
    .dec_accept(dec_accept), .dec_code(dec_code)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int hidx(logic [47:0] a, logic [1:0] ft);
    case (ft)
      2'd0: return int'((a >> 36) & 48'hFFF);
      2'd1: return int'((a >> 35) & 48'hFFF);
      2'd2: return int'((a >> 34) & 48'hFFF);
      default: return int'((a >> 32) & 48'hFFF);
    endcase
  endfunction

  function automatic logic [1:0] model_decide(logic [47:0] a, logic [1:0] ft, logic be);
    bit ex = 0;
    int ix;
    for (int e = 0; e < 16; e++)
      if (m_hi[e][31] && a == {m_hi[e][15:0], m_lo[e]}) ex = 1;
    if (ex) return 2'd1;
    if (a == 48'hFFFF_FFFF_FFFF) return be ? 2'd3 : 2'd0;
    if (a[0] == 1'b0) return 2'd0;
    ix = hidx(a, ft);
    if (m_tbl[ix / 32][ix % 32]) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic [31:0] model_read(logic [7:0] a);
    if (a < 8'd32) return a[0] ? m_hi[a / 2] : m_lo[a / 2];
    if (a >= 8'd128) return m_tbl[a - 8'd128];
    return 32'h0;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 16; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
    for (int i = 0; i < 128; i++) m_tbl[i] = '0;
  endtask

  // reference model stepped on every edge, compared just after it
  always @(posedge clk) begin
    if (!rst_n) begin
      model_clear();
      e_valid = 0; e_code = 0; e_acc = 0;
    end else begin
      e_valid = da_valid;
      e_code  = da_valid ? model_decide(da, filt_type, bcast_en) : 2'd0;
      e_acc   = (e_code != 2'd0);
      if (reg_wr_en) begin
        if (reg_addr < 8'd32) begin
          if (reg_addr[0]) m_hi[reg_addr / 2] = reg_wdata & 32'h8000_FFFF;
          else             m_lo[reg_addr / 2] = reg_wdata;
        end else if (reg_addr >= 8'd128) m_tbl[reg_addr - 8'd128] = reg_wdata;
      end
    end
    #1;
    checks++;
    if (dec_valid !== e_valid || dec_code !== e_code || dec_accept !== e_acc) begin
      errors++;
      $display("FAIL %s R9 R11 model compare: got v=%0b c=%0d a=%0b exp v=%0b c=%0d a=%0b",
               cur_req, dec_valid, dec_code, dec_accept, e_valid, e_code, e_acc);
    end
  end

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic reg_check(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s read addr %0d: got %h exp %h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic set_entry(input int n, input logic [47:0] a, input logic v);
    reg_write(8'(2 * n), a[31:0]);
    reg_write(8'(2 * n + 1), {v, 15'b0, a[47:32]});
  endtask

  task automatic hash_set(input logic [47:0] a, input logic [1:0] ft);
    int ix = hidx(a, ft);
    logic [31:0] v;
    @(negedge clk);
    reg_addr = 8'(128 + ix / 32);
    #1 v = reg_rdata;
    v[ix % 32] = 1'b1;
    reg_write(8'(128 + ix / 32), v);
  endtask

  task automatic present(input logic [47:0] a, input logic [1:0] ft, input logic be,
                         input logic [1:0] exp, input string tag);
    @(negedge clk);
    da_valid = 1; da = a; filt_type = ft; bcast_en = be;
    @(posedge clk);
    #1;
    checks++;
    if (!dec_valid || dec_code !== exp || dec_accept !== (exp != 2'd0)) begin
      errors++;
      $display("FAIL %s addr %h: got v=%0b c=%0d a=%0b exp c=%0d", tag, a,
               dec_valid, dec_code, dec_accept, exp);
    end
    @(negedge clk);
    da_valid = 0;
  endtask

  localparam logic [47:0] STATION = 48'h5544_3322_1100;
  localparam logic [47:0] BCAST   = 48'hFFFF_FFFF_FFFF;

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [47:0] mc [4];
    rst_n = 0; reg_wr_en = 0; reg_addr = 0; reg_wdata = 0;
    filt_type = 0; bcast_en = 0; da_valid = 0; da = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    cur_req = "R10";
    reg_check(8'd0, 32'h0, "R10");
    reg_check(8'd31, 32'h0, "R10");
    reg_check(8'd200, 32'h0, "R10");

    cur_req = "R1";
    set_entry(0, STATION, 1'b1);
    reg_check(8'd0, 32'h3322_1100, "R1 R6");
    reg_check(8'd1, 32'h8000_5544, "R1 R6");
    reg_write(8'd3, 32'h7FFF_0000);
    reg_check(8'd3, 32'h0, "R6");
    present(STATION, 2'd0, 1'b0, 2'd1, "R1");
    present(STATION ^ 48'h0100, 2'd0, 1'b0, 2'd0, "R1");

    cur_req = "R2";
    set_entry(5, 48'h0A0B_0C0D_0E01, 1'b0);
    present(48'h0A0B_0C0D_0E01, 2'd0, 1'b0, 2'd0, "R2");
    set_entry(5, 48'h0A0B_0C0D_0E01, 1'b1);
    present(48'h0A0B_0C0D_0E01, 2'd0, 1'b0, 2'd1, "R2");

    cur_req = "R4 R5";
    mc[0] = 48'h563A_B2C1_0E01; mc[1] = 48'hAC60_1234_5603;
    mc[2] = 48'h5D87_0F0F_0F05; mc[3] = 48'h1263_4000_0007;
    for (int t = 0; t < 4; t++) begin
      hash_set(mc[t], 2'(t));
      present(mc[t], 2'(t), 1'b0, 2'd2, "R4 R5");
    end
    present(48'h0010_0000_0001, 2'd0, 1'b0, 2'd0, "R5");
    for (int t = 0; t < 4; t++)
      reg_check(8'(128 + hidx(mc[t], 2'(t)) / 32), model_read(8'(128 + hidx(mc[t], 2'(t)) / 32)), "R5 R6");

    cur_req = "R3";
    present(mc[0] & ~48'h1, 2'd0, 1'b0, 2'd0, "R3");

    cur_req = "R7";
    present(BCAST, 2'd0, 1'b1, 2'd3, "R7");
    present(BCAST, 2'd0, 1'b0, 2'd0, "R7");
    hash_set(BCAST, 2'd0);
    present(BCAST, 2'd0, 1'b0, 2'd0, "R7");

    cur_req = "R8";
    present(BCAST, 2'd0, 1'b1, 2'd3, "R8");
    set_entry(7, mc[1], 1'b1);
    present(mc[1], 2'd1, 1'b0, 2'd1, "R8");
    set_entry(9, BCAST, 1'b1);
    present(BCAST, 2'd3, 1'b1, 2'd1, "R8");

    cur_req = "R6";
    reg_write(8'd40, 32'hDEAD_BEEF);
    reg_check(8'd40, 32'h0, "R6");
    reg_check(8'd18, model_read(8'd18), "R6");

    cur_req = "R9 back-to-back";
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      da_valid = 1; da = (i % 2 == 0) ? STATION : mc[i % 4]; filt_type = 2'(i % 4);
      @(negedge clk);
    end
    da_valid = 0;
    repeat (3) @(negedge clk);

    cur_req = "R4 R5 R8 random";
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      filt_type = 2'($urandom % 4);
      bcast_en = 1'($urandom % 2);
      da_valid = 1'($urandom % 4 != 0);
      case ($urandom % 4)
        0: da = mc[$urandom % 4];
        1: da = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFE;
        2: da = {$urandom, $urandom} | 48'h1;
        default: da = (i % 7 == 0) ? BCAST : STATION;
      endcase
      if (i % 25 == 0) begin
        reg_wr_en = 1; reg_addr = 8'(128 + $urandom % 128); reg_wdata = $urandom;
      end else reg_wr_en = 0;
    end
    @(negedge clk);
    da_valid = 0; reg_wr_en = 0;

    cur_req = "R10";
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    reg_check(8'd1, 32'h0, "R10");
    reg_check(8'(128 + hidx(mc[0], 2'd0) / 32), 32'h0, "R10");
    present(STATION, 2'd0, 1'b0, 2'd0, "R10");
    present(mc[0], 2'd0, 1'b0, 2'd0, "R10");

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule